// File: doc/BRIEF.md
# Video-locked divided clock and frame-sync generator

This block sits beside the pixel and line counters of a video output and turns their progress into two reference signals for an external clock-recovery loop: a divided-clock pulse train and a start-of-frame pulse. The divider counts pixel-step strobes, either one per strobe or one per pixel carried in the strobe's clock cycle. In the second case the pulse rate follows the multi-pixel counters exactly, and the spacing between pulses becomes uneven.

The line position is advanced by a line-start strobe, and the frame wraps after a programmable number of lines. When an external frame reference is enabled and reported stable, the block measures where the external start of frame lands in its own frame. It then moves its own frame end by one line per frame, either holding a line or skipping one, until the two frame starts agree. A locked flag reports when the two have matched within one line on two frames in a row.

Top module: `vidlock_sync_gen`

## Requirements
- R1: After a synchronous active-low reset the outputs div_pulse, sof_pulse and sof_locked are low, and the divider and line counts are zero.
- R2: With step_mode = 0 the divider adds 1 on each cycle with pix_en high. A div_pulse appears on the cycle after the count would reach div_value, and the count returns to zero. This gives one pulse every div_value counting cycles, the first on counting cycle div_value after reset.
- R3: With step_mode = 1 the divider adds PPC (default 4) on each counting cycle. When the sum reaches or passes div_value it pulses and keeps the excess. The long-run rate is PPC/div_value pulses per counting cycle. With div_value = 10 the gaps alternate 3, 2, and the first pulse is on counting cycle 3. With div_value = 12 the gaps are a uniform 3.
- R4: A div_value of zero stops div_pulse entirely and holds the divider count at zero.
- R5: On cycles with pix_en low the divider count does not move and no div_pulse is produced.
- R6: Each line_start advances the line count. On the line_start that completes frame_lines lines, the count wraps to zero and sof_pulse is high for the following cycle. Between line_start strobes the count is frozen.
- R7: When an ext_sof is accepted, the distance d is the line count after that cycle's line_start. If 0 < d < frame_lines/2, the current frame's end is held for exactly one extra line, giving a frame of frame_lines+1 lines.
- R8: If an accepted ext_sof gives d >= frame_lines/2, the last line of the frame is skipped, giving a frame of frame_lines-1 lines. A d of 0 changes nothing. At most one line is added or removed per frame, and only at the frame end.
- R9: An accepted ext_sof is within one line when d is 0, 1 or frame_lines-1. sof_locked rises after two consecutive accepted ext_sof events that are both within one line. It falls on the first accepted ext_sof that is not.
- R10: ext_sof is accepted only while both ext_sync_en and ext_locked are high. While either is low, ext_sof has no effect on frame length, any pending correction is dropped, and sof_locked is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video output clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel-step strobe; the divider counts only on these cycles |
| step_mode | input | 1 | 0: count by one; 1: count by PPC |
| div_value | input | DIV_W (12) | Divider terminal value; zero disables div_pulse |
| line_start | input | 1 | One-cycle strobe at the start of each output line |
| frame_lines | input | LINE_W (12) | Lines per frame, at least 4 |
| ext_sync_en | input | 1 | Enables use of the external frame reference |
| ext_sof | input | 1 | External start-of-frame strobe, given with a line_start |
| ext_locked | input | 1 | External reference reports itself stable |
| div_pulse | output | 1 | Divided-clock pulse, one cycle wide |
| sof_pulse | output | 1 | Internal start-of-frame pulse, one cycle wide |
| sof_locked | output | 1 | Internal frame start matches external within one line |

## Verification
A corrupted divider count shows at div_pulse within one divider period: the next pulse comes early or late by the error. In step-by-PPC mode the remainder then carries the phase error forward, so the rate stays right while the pulse phase is off. A wrong line count moves sof_pulse by the same number of lines on every frame until an external reference pulls it back, at one line per frame. A stale or misdirected correction shows at the very next frame end as a frame of frame_lines plus or minus one lines, and a wrong lock history shows in sof_locked one accepted ext_sof later.

// File: rtl/vidlock_pkg.sv
// Shared types for the video-locked sync generator.
package vidlock_pkg;
    // Pending frame-end correction requested by the alignment logic.
    typedef enum logic [1:0] {
        CORR_NONE = 2'd0,
        CORR_HOLD = 2'd1,
        CORR_ADV  = 2'd2
    } corr_e;
endpackage

// File: rtl/vidlock_div.sv
// Divided-clock generator. An accumulator advances on each pix_en cycle by
// one (step_mode=0) or by PPC (step_mode=1). When it reaches div_value it
// pulses. In PPC mode the excess is kept, so the pulse rate is exact.
// Assumes PPC < 2**DIV_W. A div_value of zero parks the accumulator.
module vidlock_div #(
    parameter int DIV_W = 12,
    parameter int PPC   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             step_mode,
    input  logic [DIV_W-1:0] div_value,
    output logic             div_pulse
);
    localparam int SUM_W = DIV_W + 1;
    localparam logic [SUM_W-1:0] STEP_WIDE = SUM_W'(PPC);
    localparam logic [SUM_W-1:0] STEP_ONE  = SUM_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] excess;
    logic             hit;

    // Next accumulator sum and terminal detection.
    always_comb begin
        sum    = {1'b0, cnt_q} + (step_mode ? STEP_WIDE : STEP_ONE);
        excess = sum - {1'b0, div_value};
        hit    = pix_en && (div_value != '0) && (sum >= {1'b0, div_value});
    end

    // Accumulator update and registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= hit;
            if (div_value == '0) begin
                cnt_q <= '0;
            end else if (pix_en) begin
                if (hit) cnt_q <= step_mode ? excess[DIV_W-1:0] : '0;
                else     cnt_q <= sum[DIV_W-1:0];
            end
        end
    end

    // R2: in unit-step mode a terminal count pulses and restarts from zero.
    a_r2_unit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !step_mode && div_value != '0 &&
         ({1'b0, cnt_q} + STEP_ONE) >= {1'b0, div_value})
        |=> (div_pulse && cnt_q == '0));

    // R4: a zero divider value never lets a pulse out.
    a_r4_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (div_value == '0) |=> !div_pulse);

    // R5: without a pixel step the accumulator is frozen and silent.
    a_r5_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en && div_value != '0) |=> ($stable(cnt_q) && !div_pulse));
endmodule

// File: rtl/vidlock_frame.sv
// Line counter of the output frame. Each line_start advances it. It wraps
// after frame_lines lines and registers a one-cycle sof_pulse. A pending
// correction is applied only at the frame end: HOLD repeats the last line
// once, ADV wraps one line early. Assumes frame_lines >= 4.
module vidlock_frame
    import vidlock_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [LINE_W-1:0] frame_lines,
    input  corr_e             corr,
    output logic [LINE_W-1:0] line_nxt,
    output logic              corr_taken,
    output logic              sof_pulse
);
    logic [LINE_W-1:0] line_cnt_q;
    logic [LINE_W-1:0] last_line;
    logic              wrap;

    // Next line position, with the frame-end correction folded in.
    always_comb begin
        last_line  = frame_lines - LINE_W'(1);
        line_nxt   = line_cnt_q;
        wrap       = 1'b0;
        corr_taken = 1'b0;
        if (line_start) begin
            if (line_cnt_q >= last_line) begin
                if (corr == CORR_HOLD) begin
                    corr_taken = 1'b1;
                end else begin
                    line_nxt = '0;
                    wrap     = 1'b1;
                end
            end else if (corr == CORR_ADV && line_cnt_q == last_line - LINE_W'(1)) begin
                line_nxt   = '0;
                wrap       = 1'b1;
                corr_taken = 1'b1;
            end else begin
                line_nxt = line_cnt_q + LINE_W'(1);
            end
        end
    end

    // Line count register and start-of-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt_q <= '0;
            sof_pulse  <= 1'b0;
        end else begin
            line_cnt_q <= line_nxt;
            sof_pulse  <= wrap;
        end
    end

    // R6: a start-of-frame pulse always coincides with line zero.
    a_r6_sof_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> (line_cnt_q == '0));

    // R6: between line strobes the position and the pulse stay put.
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> ($stable(line_cnt_q) && !sof_pulse));
endmodule

// File: rtl/vidlock_align.sv
// Alignment and lock tracking against an external start of frame. On an
// accepted ext_sof it takes the line distance d from line_nxt and requests
// a one-line hold or advance for the frame end. It also scores d for the
// lock flag. Assumes ext_sof arrives together with a line_start.
module vidlock_align
    import vidlock_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_sync_en,
    input  logic              ext_sof,
    input  logic              ext_locked,
    input  logic [LINE_W-1:0] frame_lines,
    input  logic [LINE_W-1:0] line_nxt,
    input  logic              corr_taken,
    output corr_e             corr,
    output logic              locked
);
    logic              sync_ok;
    logic              in_win;
    logic              prev_good_q;
    logic [LINE_W-1:0] half_lines;
    logic [LINE_W-1:0] last_line;
    corr_e             want;

    // Classify the distance of the external frame start.
    always_comb begin
        sync_ok    = ext_sync_en && ext_locked;
        half_lines = frame_lines >> 1;
        last_line  = frame_lines - LINE_W'(1);
        in_win     = (line_nxt == '0) || (line_nxt == LINE_W'(1)) ||
                     (line_nxt == last_line);
        if (line_nxt == '0)           want = CORR_NONE;
        else if (line_nxt < half_lines) want = CORR_HOLD;
        else                          want = CORR_ADV;
    end

    // Correction request, two-in-a-row lock history and flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !sync_ok) begin
            corr        <= CORR_NONE;
            prev_good_q <= 1'b0;
            locked      <= 1'b0;
        end else if (ext_sof) begin
            corr        <= want;
            prev_good_q <= in_win;
            locked      <= in_win && prev_good_q;
        end else if (corr_taken) begin
            corr <= CORR_NONE;
        end
    end

    // R10: without a trusted external reference nothing stays pending or locked.
    a_r10_unsync_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_sync_en && ext_locked) |=> (!locked && corr == CORR_NONE));

    // R9: the lock flag rises only on an accepted external frame start.
    a_r9_lock_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ext_sof));
endmodule

// File: rtl/vidlock_sync_gen.sv
// Top of the video-locked sync generator. It joins the divided-clock
// accumulator, the frame line counter and the external alignment tracker.
// Assumes line_start and pix_en come from the video output's own counters.
module vidlock_sync_gen
    import vidlock_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int LINE_W = 12,
    parameter int PPC    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              step_mode,
    input  logic [DIV_W-1:0]  div_value,
    input  logic              line_start,
    input  logic [LINE_W-1:0] frame_lines,
    input  logic              ext_sync_en,
    input  logic              ext_sof,
    input  logic              ext_locked,
    output logic              div_pulse,
    output logic              sof_pulse,
    output logic              sof_locked
);
    corr_e             corr;
    logic              corr_taken;
    logic [LINE_W-1:0] line_nxt;

    // Divided reference clock.
    vidlock_div #(.DIV_W(DIV_W), .PPC(PPC)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_en    (pix_en),
        .step_mode (step_mode),
        .div_value (div_value),
        .div_pulse (div_pulse)
    );

    // Frame line position and start-of-frame pulse.
    vidlock_frame #(.LINE_W(LINE_W)) frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (line_start),
        .frame_lines (frame_lines),
        .corr        (corr),
        .line_nxt    (line_nxt),
        .corr_taken  (corr_taken),
        .sof_pulse   (sof_pulse)
    );

    // External frame alignment and lock flag.
    vidlock_align #(.LINE_W(LINE_W)) align_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_sync_en (ext_sync_en),
        .ext_sof     (ext_sof),
        .ext_locked  (ext_locked),
        .frame_lines (frame_lines),
        .line_nxt    (line_nxt),
        .corr_taken  (corr_taken),
        .corr        (corr),
        .locked      (sof_locked)
    );
endmodule

// File: tb/vidlock_sync_gen_tb_top.sv
// Directed bench: each scenario task drives and checks its own results.
module vidlock_sync_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pix_en, step_mode, line_start, ext_sync_en, ext_sof, ext_locked;
    logic [11:0] div_value, frame_lines;
    logic        div_pulse, sof_pulse, sof_locked;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 0;
    int pos [0:63];

    always #5 clk = ~clk;

    vidlock_sync_gen dut_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .step_mode(step_mode),
        .div_value(div_value), .line_start(line_start), .frame_lines(frame_lines),
        .ext_sync_en(ext_sync_en), .ext_sof(ext_sof), .ext_locked(ext_locked),
        .div_pulse(div_pulse), .sof_pulse(sof_pulse), .sof_locked(sof_locked)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; pix_en = 0; step_mode = 0; line_start = 0;
        ext_sync_en = 0; ext_sof = 0; ext_locked = 0;
        div_value = 12'd0; frame_lines = 12'd8;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // Run n cycles with pix_en (alternating if alt), recording pulse cycles.
    task automatic run_div(input int n, input bit alt, output int total);
        total = 0;
        for (int i = 1; i <= n; i++) begin
            pix_en = alt ? bit'(i % 2) : 1'b1;
            @(negedge clk);
            if (div_pulse) begin
                if (total < 64) pos[total] = i;
                total++;
            end
        end
        pix_en = 0;
    endtask

    // One line of four cycles; line_start on the first, ext_sof optional.
    task automatic do_line(input bit ext, output bit sof);
        line_start = 1; ext_sof = ext;
        @(negedge clk);
        sof = sof_pulse;
        line_start = 0; ext_sof = 0;
        repeat (3) @(negedge clk);
    endtask

    // Lines until the next sof; ext_sof on line number 'at' (0 = none).
    task automatic frame(input int at, output int gap);
        bit s;
        gap = 0;
        do begin
            gap++;
            do_line(gap == at, s);
        end while (!s && gap < 20);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 div_pulse", div_pulse, 0);
        chk("R1 sof_pulse", sof_pulse, 0);
        chk("R1 sof_locked", sof_locked, 0);
    endtask

    task automatic t_unit_step();
        int tot;
        do_reset();
        div_value = 12'd5; step_mode = 0;
        run_div(20, 0, tot);
        chk("R2 pulse count", tot, 4);
        chk("R2 first pulse", pos[0], 5);
        chk("R2 gap", pos[1] - pos[0], 5);
    endtask

    task automatic t_ppc_step();
        int tot;
        do_reset();
        div_value = 12'd10; step_mode = 1;
        run_div(20, 0, tot);
        chk("R3 pulse count div10", tot, 8);
        chk("R3 first pulse", pos[0], 3);
        chk("R3 gap a", pos[1] - pos[0], 2);
        chk("R3 gap b", pos[2] - pos[1], 3);
        do_reset();
        div_value = 12'd12; step_mode = 1;
        run_div(20, 0, tot);
        chk("R3 pulse count div12", tot, 6);
        chk("R3 uniform gap", pos[2] - pos[1], 3);
    endtask

    task automatic t_zero_div();
        int tot;
        do_reset();
        div_value = 12'd0; step_mode = 0;
        run_div(30, 0, tot);
        chk("R4 no pulses", tot, 0);
    endtask

    task automatic t_pix_gate();
        int tot;
        do_reset();
        div_value = 12'd5; step_mode = 0;
        run_div(20, 1, tot);
        chk("R5 gated count", tot, 2);
        chk("R5 gated gap", pos[1] - pos[0], 10);
    endtask

    task automatic t_frame();
        int g;
        do_reset();
        frame_lines = 12'd8;
        frame(0, g); chk("R6 first frame", g, 8);
        frame(0, g); chk("R6 second frame", g, 8);
        frame_lines = 12'd5;
        frame(0, g); chk("R6 short frame", g, 5);
        frame_lines = 12'd8;
    endtask

    task automatic t_align();
        int g;
        do_reset();
        frame_lines = 12'd8; ext_sync_en = 1; ext_locked = 1;
        frame(0, g);
        frame(8, g); chk("R9 one good, not locked", sof_locked, 0);
        chk("R8 aligned no change", g, 8);
        frame(8, g); chk("R9 two good, locked", sof_locked, 1);
        frame(3, g); chk("R7 hold one line", g, 9);
        chk("R9 out of window clears", sof_locked, 0);
        frame(8, g); frame(8, g); chk("R9 relock", sof_locked, 1);
        frame(6, g); chk("R8 advance one line", g, 7);
        chk("R9 cleared after d=6", sof_locked, 0);
        frame(1, g); chk("R7 d=1 hold", g, 9);
        frame(8, g); chk("R9 d=1 counts in window", sof_locked, 1);
    endtask

    task automatic t_unsync();
        int g;
        ext_locked = 0;
        frame(3, g); chk("R10 ext_locked low ignored", g, 8);
        chk("R10 lock dropped", sof_locked, 0);
        ext_locked = 1; ext_sync_en = 0;
        frame(6, g); chk("R10 ext disabled ignored", g, 8);
        chk("R10 lock low while disabled", sof_locked, 0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_unit_step();
        t_ppc_step();
        t_zero_div();
        t_pix_gate();
        t_frame();
        t_align();
        t_unsync();
        report();
        $finish;
    end
endmodule